// File: doc/BRIEF.md
# Push-Button Emergency Power Cut-Off Controller

This block lets a service technician cut power to an embedded battery pack with a single push button, and then bring it back. It watches an active-low button input and drives two power-switch enables, one on the charge path and one on the discharge path. The two enables always move together. A debounced press, meaning a high-to-low change of the button level, toggles the pair. While the switches are off, an optional timer restores power on its own after a configured number of seconds.

The raw button input is first resynchronised to the system clock. It then passes a debounce filter that runs on a 1 kHz tick derived from that clock. A new level is accepted only after it has held for 16 ticks in a row. Only the accepted falling change counts as a press. The timer limit comes from a parallel configuration port. A limit of zero turns the timer off, so that only a press can restore power. The gate drivers and the storage that holds the limit are outside this block.

Top module: `sd_pushbutton_ctrl`

## Requirements
- R1: After reset is released, `chg_en_o` and `dsg_en_o` are both 1 and the block is in the on state.
- R2: `chg_en_o` and `dsg_en_o` are equal in every cycle.
- R3: A debounced falling change of the button level (1 to 0) while the enables are 1 clears both enables on the clock edge at which the change is accepted.
- R4: A debounced rising change of the button level (0 to 1) leaves the enables unchanged.
- R5: A debounced falling change while the enables are 0 sets both enables to 1 on the clock edge at which the change is accepted.
- R6: While off, a timer counts whole seconds of `TICKS_PER_SEC` ticks. With a nonzero `timeout_s_i`, the enables return to 1 one cycle after the elapsed-second count reaches `timeout_s_i`.
- R7: When `timeout_s_i` is 0 the timer never restores power, and the enables stay 0 until the next accepted press.
- R8: The elapsed-time count is cleared whenever the block is on, so each entry into the off state starts a full timeout window.
- R9: The button passes two synchroniser flops. A level change is accepted only once the synchronised level has differed from the accepted level on `DEBOUNCE_TICKS` consecutive ticks. A shorter glitch is ignored, and so is any glitch that returns before the count completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Raw push-button level, low when pressed, asynchronous |
| timeout_s_i | input | TO_W | Auto-restore timeout in seconds, 0 disables |
| chg_en_o | output | 1 | Charge switch enable, 1 closes the switch |
| dsg_en_o | output | 1 | Discharge switch enable, 1 closes the switch |

## Verification
All of the block's state reaches the two enables. A wrong on/off state shows on both outputs in the very cycle after the faulty edge. A debounce counter that runs long or short moves the accept edge by whole tick periods. A timer that is not cleared on entry, or that counts wrongly, moves the restore edge by one or more tick periods. A behavioural model is compared with the enables on every clock, so each of these errors is reported in the first cycle where the enables differ from the model.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic {
    SD_ON  = 1'b0,
    SD_OFF = 1'b1
  } sd_state_e;

  localparam int unsigned SD_NUM_SW = 2; // charge, discharge
endpackage

// File: rtl/sd_tick_gen.sv
module sd_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sd_debounce.sv
module sd_debounce #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICKS       = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_lvl;
  logic                   level_q;
  logic [CW-1:0]          cnt_q;
  logic                   accept;

  // idle level of the button is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign s_lvl  = sync_q[SYNC_STAGES-1];
  assign accept = (s_lvl != level_q) && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else if (s_lvl == level_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        level_q <= s_lvl;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign fall_o  = accept && !s_lvl;
endmodule

// File: rtl/sd_timeout.sv
module sd_timeout #(
  parameter int unsigned TO_W          = 16,
  parameter int unsigned TICKS_PER_SEC = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic [TO_W-1:0] sec_o,
  output logic            expire_o
);
  localparam int unsigned SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_SEC - 1);

  logic [SW-1:0]   sub_q;
  logic [TO_W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      sec_q <= '0;
    end else if (!run_i) begin
      sub_q <= '0;
      sec_q <= '0;
    end else if (tick_i) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign sec_o    = sec_q;
  assign expire_o = run_i && (limit_i != '0) && (sec_q >= limit_i);
endmodule

// File: rtl/sd_pushbutton_ctrl.sv
module sd_pushbutton_ctrl
  import sd_pkg::*;
#(
  parameter int unsigned TICK_DIV       = 50000, // 50 MHz -> 1 kHz
  parameter int unsigned DEBOUNCE_TICKS = 16,
  parameter int unsigned TICKS_PER_SEC  = 1000,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned TO_W           = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            btn_i,
  input  logic [TO_W-1:0] timeout_s_i,
  output logic            chg_en_o,
  output logic            dsg_en_o
);
  logic            tick_w;
  logic            level_w;
  logic            fall_w;
  logic            expire_w;
  logic [TO_W-1:0] sec_w;
  sd_state_e       state_q, state_d;
  logic [SD_NUM_SW-1:0] en_q;

  sd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  sd_debounce #(.SYNC_STAGES(SYNC_STAGES), .TICKS(DEBOUNCE_TICKS)) u_db (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_w),
    .raw_i  (btn_i),
    .level_o(level_w),
    .fall_o (fall_w)
  );

  sd_timeout #(.TO_W(TO_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_to (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .run_i   (state_q == SD_OFF),
    .limit_i (timeout_s_i),
    .sec_o   (sec_w),
    .expire_o(expire_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SD_ON:  if (fall_w)             state_d = SD_OFF;
      SD_OFF: if (fall_w || expire_w) state_d = SD_ON;
      default:                        state_d = SD_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SD_ON;
    else         state_q <= state_d;
  end

  // one output flop per switch, placed next to its driver
  for (genvar g = 0; g < SD_NUM_SW; g++) begin : g_sw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[g] <= 1'b1;
      else         en_q[g] <= (state_d == SD_ON);
    end
  end

  assign chg_en_o = en_q[0];
  assign dsg_en_o = en_q[1];
endmodule

// File: rtl/sd_pushbutton_chk.sv
module sd_pushbutton_chk #(
  parameter int unsigned TO_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            chg_en_o,
  input logic            dsg_en_o,
  input logic            fall_w,
  input logic            expire_w,
  input logic            level_w,
  input logic [TO_W-1:0] timeout_s_i,
  input logic [TO_W-1:0] sec_w
);
  // R2
  en_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_en_o == dsg_en_o);

  // R3
  press_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_w && chg_en_o) |=> !chg_en_o && !dsg_en_o);

  // R5
  press_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_w && !chg_en_o) |=> chg_en_o && dsg_en_o);

  // R6
  expire_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_w && !chg_en_o) |=> chg_en_o);

  // R7
  zero_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_s_i == '0) |-> !expire_w);

  // R4
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_w && !expire_w) |=> $stable(chg_en_o));

  // R4
  rise_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_w) |-> !$past(fall_w));

  // R8
  sec_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_en_o |=> (sec_w == '0));
endmodule

bind sd_pushbutton_ctrl sd_pushbutton_chk #(.TO_W(TO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chg_en_o   (chg_en_o),
  .dsg_en_o   (dsg_en_o),
  .fall_w     (fall_w),
  .expire_w   (expire_w),
  .level_w    (level_w),
  .timeout_s_i(timeout_s_i),
  .sec_w      (sec_w)
);

// File: tb/sd_pushbutton_ctrl_test.sv
module sd_pushbutton_ctrl_test;
  localparam int DIV  = 4;
  localparam int DB   = 16;
  localparam int TPS  = 10;
  localparam int TO_W = 8;
  localparam int SEC  = DIV * TPS; // cycles per second

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            btn = 1'b1;
  logic [TO_W-1:0] to_cfg = '0;
  logic            chg, dsg;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  sd_pushbutton_ctrl #(
    .TICK_DIV(DIV), .DEBOUNCE_TICKS(DB), .TICKS_PER_SEC(TPS),
    .SYNC_STAGES(2), .TO_W(TO_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .timeout_s_i(to_cfg),
    .chg_en_o(chg), .dsg_en_o(dsg)
  );

  // behavioural reference
  int m_div, m_dbc, m_sub, m_sec;
  bit m_s1, m_s2, m_db, m_on;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_dbc = 0; m_sub = 0; m_sec = 0;
      m_s1 = 1; m_s2 = 1; m_db = 1; m_on = 1;
    end else begin
      bit tick, fall, expire;
      tick = (m_div == DIV - 1);
      fall = 0;
      if (m_s2 == m_db) m_dbc = 0;
      else if (tick) begin
        if (m_dbc == DB - 1) begin
          m_db = m_s2; m_dbc = 0; fall = !m_s2;
        end else m_dbc++;
      end
      expire = !m_on && (to_cfg != 0) && (m_sec >= int'(to_cfg));
      if (m_on) begin m_sub = 0; m_sec = 0; end
      else if (tick) begin
        if (m_sub == TPS - 1) begin m_sub = 0; m_sec = (m_sec + 1) % 256; end
        else m_sub++;
      end
      if (m_on && fall) m_on = 0;
      else if (!m_on && (fall || expire)) m_on = 1;
      m_s2 = m_s1; m_s1 = btn;
      m_div = tick ? 0 : m_div + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (chg != m_on || dsg != m_on) begin
        fails++;
        $display("FAIL R2/R3 model cycle: chg=%0b dsg=%0b expected %0b", chg, dsg, m_on);
      end
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic hold(input bit lvl, input int n);
    @(negedge clk);
    btn = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic press();
    hold(1'b0, 120);
    hold(1'b1, 120);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 chg after reset", chg, 1'b1);
    check("R1 dsg after reset", dsg, 1'b1);

    // R9: glitch shorter than the debounce window
    hold(1'b0, 40);
    hold(1'b1, 100);
    check("R9 glitch ignored", chg, 1'b1);

    // R3 then R4
    hold(1'b0, 120);
    check("R3 press turns off chg", chg, 1'b0);
    check("R3 press turns off dsg", dsg, 1'b0);
    hold(1'b1, 120);
    check("R4 release ignored", chg, 1'b0);

    // R5
    press();
    check("R5 second press restores", chg, 1'b1);
    check("R2 enables equal", dsg, chg);

    // R6: 8 s timeout = 320 cycles from entry
    to_cfg = 8'd8;
    press();
    check("R6 not yet expired", chg, 1'b0);
    repeat (200) @(negedge clk);
    check("R6 timeout restores", chg, 1'b1);

    // R8: partial window then re-entry starts a fresh window
    press();
    press();
    check("R8 restored by press", chg, 1'b1);
    press();
    repeat (60) @(negedge clk);
    check("R8 fresh window still off", chg, 1'b0);
    repeat (140) @(negedge clk);
    check("R8 fresh window expired", chg, 1'b1);

    // R7
    to_cfg = 8'd0;
    press();
    repeat (2000) @(negedge clk);
    check("R7 zero timeout holds off", chg, 1'b0);
    press();
    check("R7 press restores", chg, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule